// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous 16-bit parallel flash bus and drives it from a synchronous clock. The host presents one request (word program, whole-array erase, erase of everything outside the boot region, or identifier read) and holds it until acknowledged. The sequencer then expands the request into its fixed script of unlock and command bus cycles. Every write strobe is shaped with a setup phase, a low pulse and a high recovery phase, each a whole number of clock cycles.

Program and erase requests end by polling. The sequencer issues repeated reads at the host address until two consecutive reads agree on data bit 6. It then raises a one-cycle completion pulse together with the last word read. If bit 6 still differs after a bounded number of reads, the completion pulse carries an error flag. An identifier request enters identification mode, reads one word at the host address, leaves the mode again and returns the word. Bus turnaround is reduced to a single drive-enable output.

All timing values are given in nanoseconds and turned into clock counts by rounding up against the clock period, with a floor of one cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: `ack` is high exactly in a cycle where the sequencer is idle and `req` is high, and the bus cycle script starts in the next cycle. A request raised while the completion pulse is out is not acknowledged in that cycle but in the next one.
- R2: Word program (`req_op`=0) writes, in order, 0x00AA at 0x5555, 0x0055 at 0x2AAA, 0x00A0 at 0x5555, then `req_data` at `req_addr`.
- R3: Whole-array erase (`req_op`=1) and outside-boot erase (`req_op`=2) write, in order, 0x00AA@0x5555, 0x0055@0x2AAA, 0x0080@0x5555, 0x00AA@0x5555, 0x0055@0x2AAA, and then 0x0010 (op 1) or 0x0030 (op 2) at 0x5555.
- R4: Identifier read (`req_op`=3) writes 0x00AA@0x5555, 0x0055@0x2AAA and 0x0090@0x5555, then does one read at `req_addr`, then writes 0x00F0@0x5555, with no polling. The completion pulse carries the read word on `rdata` and `err`=0.
- R5: In each write cycle, chip enable is low, output enable is high and `f_dq_oe` is high throughout. Address and data are valid for T_AS cycles before the write strobe falls. The strobe stays low for T_WP cycles and then high for T_WPH cycles, with address and data unchanged.
- R6: Each read drives output enable low for T_RD cycles, with `f_dq_oe` low, and samples `f_din` in the last of those cycles. Output enable then stays high for T_OEH cycles. Polling reads all use `req_addr`.
- R7: Polling ends after the first read whose bit 6 equals that of the read before it. The completion pulse then follows the high phase of that read, with `err`=0 and `rdata` set to that read's word.
- R8: If POLL_MAX reads pass without a match, the completion pulse follows the last one with `err`=1 and `rdata` set to the last word read. A match on read number POLL_MAX counts as success.
- R9: After reset and between requests, chip, output and write enables are high, `f_dq_oe` is low and `f_addr`/`f_dout` are zero. `done` is a single-cycle pulse during which chip enable is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until `ack` |
| req_op | input | 2 | 0 program, 1 whole erase, 2 outside-boot erase, 3 identifier read |
| req_addr | input | ADDR_W | Target / polling / identifier address |
| req_data | input | DATA_W | Word to program |
| ack | output | 1 | Request accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll bound exceeded, valid with `done` |
| rdata | output | DATA_W | Last word read, valid with `done` |
| f_addr | output | ADDR_W | Flash address |
| f_dout | output | DATA_W | Flash write data |
| f_din | input | DATA_W | Flash read data |
| f_dq_oe | output | 1 | Host drives the data bus |
| f_ce_n | output | 1 | Chip enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_we_n | output | 1 | Write strobe, active low |

## Verification
Two events can land on the same cycle. A new request can arrive while the completion pulse of the previous one is out. The bit-6 match can come on the very read that exhausts the poll bound. The bench raises a request exactly in the completion cycle of a whole-array erase and expects `ack` low there and high one cycle later, with no change to the completion outputs. It also scripts the flash model so that the match comes on read POLL_MAX, where the completion must carry `err`=0. A second erase keeps toggling past the bound and must end with `err`=1.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_CHIP_ERASE = 2'd1,
        OP_MAIN_ERASE = 2'd2,
        OP_ID_READ    = 2'd3
    } flash_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RLOW, ST_RHIGH, ST_DONE
    } seq_state_e;

    typedef enum logic { CYC_WRITE, CYC_READ } cyc_kind_e;
    typedef enum logic [1:0] { AD_UNLOCK1, AD_UNLOCK2, AD_HOST } addr_sel_e;

    typedef struct packed {
        cyc_kind_e kind;
        addr_sel_e asel;
        logic      host_data;
        logic [7:0] code;
    } script_entry_t;

    localparam logic [15:0] UNLOCK1_ADDR = 16'h5555;
    localparam logic [15:0] UNLOCK2_ADDR = 16'h2AAA;

    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] script_len(input flash_op_e op);
        case (op)
            OP_PROG:    return 3'd4;
            OP_ID_READ: return 3'd5;
            default:    return 3'd6;
        endcase
    endfunction

    function automatic logic op_polls(input flash_op_e op);
        return op != OP_ID_READ;
    endfunction

    function automatic script_entry_t wr(input addr_sel_e a, input logic [7:0] c);
        script_entry_t e;
        e.kind = CYC_WRITE; e.asel = a; e.host_data = 1'b0; e.code = c;
        return e;
    endfunction

    function automatic script_entry_t script_step(input flash_op_e op, input logic [2:0] idx);
        script_entry_t e;
        case (idx)
            3'd0: e = wr(AD_UNLOCK1, 8'hAA);
            3'd1: e = wr(AD_UNLOCK2, 8'h55);
            3'd2: e = wr(AD_UNLOCK1, (op == OP_PROG) ? 8'hA0 :
                                     (op == OP_ID_READ) ? 8'h90 : 8'h80);
            3'd3: begin
                if (op == OP_PROG) begin
                    e = wr(AD_HOST, 8'h00);
                    e.host_data = 1'b1;
                end else if (op == OP_ID_READ) begin
                    e = wr(AD_HOST, 8'h00);
                    e.kind = CYC_READ;
                end else begin
                    e = wr(AD_UNLOCK1, 8'hAA);
                end
            end
            3'd4: e = (op == OP_ID_READ) ? wr(AD_UNLOCK1, 8'hF0) : wr(AD_UNLOCK2, 8'h55);
            default: e = wr(AD_UNLOCK1, (op == OP_CHIP_ERASE) ? 8'h10 : 8'h30);
        endcase
        return e;
    endfunction

endpackage

// File: rtl/flash_seq_script.sv
module flash_seq_script
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  flash_op_e          op,
    input  logic [2:0]         idx,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_data,
    output cyc_kind_e          kind,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  data
);
    script_entry_t ent;

    always_comb begin
        ent  = script_step(op, idx);
        kind = ent.kind;
        case (ent.asel)
            AD_UNLOCK1: addr = ADDR_W'(UNLOCK1_ADDR);
            AD_UNLOCK2: addr = ADDR_W'(UNLOCK2_ADDR);
            default:    addr = host_addr;
        endcase
        if (ent.host_data) data = host_data;
        else               data = DATA_W'(ent.code);
    end
endmodule

// File: rtl/flash_seq_toggle.sv
module flash_seq_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic capture,
    input  logic bit_in,
    output logic settled
);
    logic prev_q, have_prev_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
            settled     <= 1'b0;
        end else if (capture) begin
            prev_q      <= bit_in;
            have_prev_q <= 1'b1;
            settled     <= have_prev_q && (prev_q == bit_in);
        end
    end

    // R7: a fresh request never starts with a stale match
    assert_clear_settle_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> !settled);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CLK_PS   = 5000,
    parameter int TAS_NS   = 5,
    parameter int TWP_NS   = 90,
    parameter int TWPH_NS  = 90,
    parameter int TRD_NS   = 40,
    parameter int TOEH_NS  = 150,
    parameter int POLL_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ack,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] f_addr,
    output logic [DATA_W-1:0] f_dout,
    input  logic [DATA_W-1:0] f_din,
    output logic              f_dq_oe,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);
    localparam int T_AS   = ns_to_cyc(TAS_NS, CLK_PS);
    localparam int T_WP   = ns_to_cyc(TWP_NS, CLK_PS);
    localparam int T_WPH  = ns_to_cyc(TWPH_NS, CLK_PS);
    localparam int T_RD   = ns_to_cyc(TRD_NS, CLK_PS);
    localparam int T_OEH  = ns_to_cyc(TOEH_NS, CLK_PS);
    localparam int T_MAX  = max_of(max_of(max_of(T_AS, T_WP), max_of(T_WPH, T_RD)), T_OEH);
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    seq_state_e          state_q;
    flash_op_e           op_q;
    logic [CNT_W-1:0]    cnt_q, phase_len;
    logic [2:0]          step_q;
    logic [POLL_W-1:0]   polls_q;
    logic                polling_q, err_q, settled, last;
    logic [ADDR_W-1:0]   addr_q, ent_addr;
    logic [DATA_W-1:0]   data_q, ent_data, rdata_q;
    cyc_kind_e           ent_kind;
    script_entry_t       nxt_ent;

    flash_seq_script #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_script (
        .op(op_q), .idx(step_q), .host_addr(addr_q), .host_data(data_q),
        .kind(ent_kind), .addr(ent_addr), .data(ent_data)
    );

    flash_seq_toggle u_toggle (
        .clk(clk), .rst(rst), .clear(ack),
        .capture(state_q == ST_RLOW && last && polling_q),
        .bit_in(f_din[6]), .settled(settled)
    );

    always_comb begin
        case (state_q)
            ST_WSETUP: phase_len = CNT_W'(T_AS);
            ST_WPULSE: phase_len = CNT_W'(T_WP);
            ST_WHOLD:  phase_len = CNT_W'(T_WPH);
            ST_RLOW:   phase_len = CNT_W'(T_RD);
            ST_RHIGH:  phase_len = CNT_W'(T_OEH);
            default:   phase_len = CNT_W'(1);
        endcase
        last    = (cnt_q == phase_len - CNT_W'(1));
        nxt_ent = script_step(op_q, step_q + 3'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_PROG;
            cnt_q     <= '0;
            step_q    <= '0;
            polls_q   <= '0;
            polling_q <= 1'b0;
            err_q     <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            rdata_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req) begin
                    op_q      <= flash_op_e'(req_op);
                    addr_q    <= req_addr;
                    data_q    <= req_data;
                    step_q    <= '0;
                    cnt_q     <= '0;
                    polls_q   <= '0;
                    polling_q <= 1'b0;
                    err_q     <= 1'b0;
                    state_q   <= ST_WSETUP;
                end
                ST_WSETUP, ST_WPULSE: begin
                    if (last) begin
                        cnt_q   <= '0;
                        state_q <= (state_q == ST_WSETUP) ? ST_WPULSE : ST_WHOLD;
                    end else cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_RLOW: begin
                    if (last) begin
                        cnt_q   <= '0;
                        rdata_q <= f_din;
                        if (polling_q) polls_q <= polls_q + POLL_W'(1);
                        state_q <= ST_RHIGH;
                    end else cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_WHOLD, ST_RHIGH: begin
                    if (!last) cnt_q <= cnt_q + CNT_W'(1);
                    else begin
                        cnt_q <= '0;
                        if (polling_q) begin
                            if (settled) state_q <= ST_DONE;
                            else if (polls_q == POLL_W'(POLL_MAX)) begin
                                err_q   <= 1'b1;
                                state_q <= ST_DONE;
                            end else state_q <= ST_RLOW;
                        end else if (step_q == script_len(op_q) - 3'd1) begin
                            if (op_polls(op_q)) begin
                                polling_q <= 1'b1;
                                state_q   <= ST_RLOW;
                            end else state_q <= ST_DONE;
                        end else begin
                            step_q  <= step_q + 3'd1;
                            state_q <= (nxt_ent.kind == CYC_READ) ? ST_RLOW : ST_WSETUP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        f_ce_n  = !(state_q inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RLOW, ST_RHIGH});
        f_we_n  = (state_q != ST_WPULSE);
        f_oe_n  = (state_q != ST_RLOW);
        f_dq_oe = (state_q inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
        f_addr  = f_ce_n ? '0 : (polling_q ? addr_q : ent_addr);
        f_dout  = f_dq_oe ? ent_data : '0;
        ack     = (state_q == ST_IDLE) && req;
        done    = (state_q == ST_DONE);
        err     = err_q;
        rdata   = rdata_q;
    end

    // ---------------- checks ----------------
    logic [CNT_W:0] we_lo_cnt;
    always_ff @(posedge clk) begin
        if (rst || f_we_n) we_lo_cnt <= '0;
        else if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    assert_we_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(f_we_n) |-> (we_lo_cnt >= (CNT_W+1)'(T_WP)));

    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        f_dq_oe |-> (f_oe_n && !f_ce_n));

    assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !f_we_n |=> (f_we_n || ($stable(f_addr) && $stable(f_dout))));

    assert_accept_starts_R1: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!f_ce_n && !ack));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (f_ce_n && f_we_n && f_oe_n) ##1 !done);

    always_comb begin
        if (!rst) assert_poll_bound_R8: assert (polls_q <= POLL_W'(POLL_MAX));
    end
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    import flash_seq_pkg::*;

    localparam int A_S = 2, W_P = 3, W_H = 2, R_L = 2, O_H = 3, PMAX = 6;

    logic clk = 1'b0, rst = 1'b1, req = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = '0, req_data = '0;
    logic ack, done, err, f_dq_oe, f_ce_n, f_oe_n, f_we_n;
    logic [15:0] rdata, f_addr, f_dout, f_din;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rd_idx = 0, k_busy = 0;
    logic [15:0] final_val = '0;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.CLK_PS(5000), .TAS_NS(10), .TWP_NS(15), .TWPH_NS(10),
                    .TRD_NS(10), .TOEH_NS(15), .POLL_MAX(PMAX)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .req(req), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .ack(ack), .done(done), .err(err), .rdata(rdata),
        .f_addr(f_addr), .f_dout(f_dout), .f_din(f_din), .f_dq_oe(f_dq_oe),
        .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n));

    // flash model: reads 1..k_busy toggle bit 6, later reads return final_val
    function automatic logic [15:0] resp(input int i, input int k, input logic [15:0] fin);
        if (i <= k) return (16'h1234 & ~16'h0040) | (16'((i % 2)) << 6);
        return fin;
    endfunction
    always @(negedge f_oe_n) rd_idx <= rd_idx + 1;
    assign f_din = resp(rd_idx, k_busy, final_val);

    typedef struct {
        logic [3:0]  ctl;   // ce_n, oe_n, we_n, dq_oe
        logic [15:0] a, d;
        logic        dn, er;
        logic [15:0] rd;
        string       tag;
    } rec_t;
    rec_t q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [15:0] a, d, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            rec_t r;
            r.ctl = c; r.a = a; r.d = d; r.dn = 1'b0; r.er = 1'b0; r.rd = '0; r.tag = t;
            q.push_back(r);
        end
    endtask

    task automatic push_wr(input logic [15:0] a, d, input string t);
        push(4'b0111, a, d, t, A_S);
        push(4'b0101, a, d, t, W_P);
        push(4'b0111, a, d, t, W_H);
    endtask

    task automatic push_rd(input logic [15:0] a);
        push(4'b0010, a, 16'h0, "R6 read low", R_L);
        push(4'b0110, a, 16'h0, "R6 read high", O_H);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] a, d, input int k,
                          input logic [15:0] fin, input bit early);
        string wt;
        int n; bit e; logic [15:0] exp_rd;
        rec_t r;
        wt = (op == 2'd0) ? "R2,R5 write" : (op == 2'd3) ? "R4,R5 write" : "R3,R5 write";
        push_wr(16'h5555, 16'h00AA, wt);
        push_wr(16'h2AAA, 16'h0055, wt);
        if (op == 2'd0) begin
            push_wr(16'h5555, 16'h00A0, wt);
            push_wr(a, d, wt);
        end else if (op == 2'd3) begin
            push_wr(16'h5555, 16'h0090, wt);
            push_rd(a);
            push_wr(16'h5555, 16'h00F0, wt);
        end else begin
            push_wr(16'h5555, 16'h0080, wt);
            push_wr(16'h5555, 16'h00AA, wt);
            push_wr(16'h2AAA, 16'h0055, wt);
            push_wr(16'h5555, (op == 2'd1) ? 16'h0010 : 16'h0030, wt);
        end
        e = 1'b0;
        if (op == 2'd3) exp_rd = resp(1, k, fin);
        else begin
            n = PMAX; e = 1'b1;
            for (int i = 2; i <= PMAX; i++)
                if (resp(i, k, fin)[6] == resp(i - 1, k, fin)[6]) begin n = i; e = 1'b0; break; end
            for (int i = 1; i <= n; i++) push_rd(a);
            exp_rd = resp(n, k, fin);
        end
        r.ctl = 4'b1110; r.a = '0; r.d = '0; r.dn = 1'b1; r.er = e; r.rd = exp_rd;
        r.tag = (op == 2'd3) ? "R4 done" : (e ? "R8 done" : "R7 done");
        q.push_back(r);

        if (!early) @(negedge clk);
        k_busy = k; final_val = fin; rd_idx = 0;
        req_op = op; req_addr = a; req_data = d; req = 1'b1;
        #1;
        if (early) begin
            chk(ack == 1'b0, "R1 ack in done cycle", 64'(ack), 64'h0);
            @(negedge clk); #1;
        end
        chk(ack == 1'b1, "R1 ack when idle", 64'(ack), 64'h1);
        @(negedge clk);
        req = 1'b0;
        while (q.size() != 0) begin
            logic [63:0] act, exp;
            r = q.pop_front();
            act = {26'h0, f_ce_n, f_oe_n, f_we_n, f_dq_oe, f_addr, f_dout, done, ack};
            exp = {26'h0, r.ctl, r.a, r.d, r.dn, 1'b0};
            chk(act == exp, r.tag, act, exp);
            if (r.dn) chk({err, rdata} == {r.er, r.rd}, r.tag, 64'({err, rdata}), 64'({r.er, r.rd}));
            if (q.size() != 0) @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk({f_ce_n, f_oe_n, f_we_n, f_dq_oe, done, f_addr} == {5'b11100, 16'h0}, "R9 reset idle",
            64'({f_ce_n, f_oe_n, f_we_n, f_dq_oe, done, f_addr}), 64'({5'b11100, 16'h0}));
        run_op(2'd0, 16'h2345, 16'hBEEF, 3, 16'hBEEF, 1'b0);   // R7 match on read 4
        run_op(2'd1, 16'h0100, 16'h0000, 4, 16'hFFFF, 1'b0);   // R8 match exactly on read PMAX
        run_op(2'd2, 16'h3000, 16'h0000, 10, 16'hFFFF, 1'b1);  // R1 collision, R8 timeout
        run_op(2'd3, 16'h0001, 16'h0000, 0, 16'h0087, 1'b0);   // R4 identifier
        run_op(2'd0, 16'h7FFE, 16'h0000, 0, 16'h0000, 1'b0);   // R7 settle on second read
        @(negedge clk);
        chk({f_ce_n, f_oe_n, f_we_n, f_dq_oe, done} == 5'b11100, "R9 idle after op",
            64'({f_ce_n, f_oe_n, f_we_n, f_dq_oe, done}), 64'(5'b11100));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule